// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a compact 16-bit accumulator machine. It holds a program counter, an address register, an instruction register, a data register, a 16-bit accumulator and a one-bit extend flag that catches the carry. Program and data share a single 256-word by 16-bit store. A sequence counter steps through timing states T0, T1, T2 and onward. In each state the control selects a fixed set of register transfers, so one instruction is fetched, decoded and executed per pass.

The instruction word keeps its opcode in bits 14..12, read through a 3-to-8 decoder, and its address in the low bits. Memory-reference instructions load, add and store the accumulator. The opcode-7 group works on the accumulator and extend flag, and each operation there is picked by one bit of the low twelve. Before the machine runs, the memory is filled through a load port, and the core holds still while that port is in use. The accumulator, extend flag and program counter appear on debug outputs.

Top module: `accCpuCore`

## Requirements
- R1: While `loadEn` is high, `loadData` is written to word `loadAddr` at each rising edge, and the core changes no register: PC, AC, E and the timing state hold until `loadEn` falls.
- R2: A synchronous active-high `rst` clears PC, AC, E, the timing state and the halted condition. Memory contents are kept.
- R3: Each instruction is fetched in three states. At T0 the address register takes PC. At T1 the instruction register takes the addressed word and PC increments. At T2 the address register takes instruction bits 7..0. Bits 11..8 of the address field play no part in addressing.
- R4: The operation comes from bits 14..12 decoded to one of eight lines. For opcodes 1, 2 and 3, bit 15 is ignored.
- R5: Opcode 2 (0x2aaa) copies memory word aaa into AC and leaves E unchanged. The new AC appears at the fifth edge of the instruction.
- R6: Opcode 1 (0x1aaa) adds memory word aaa to AC, takes the sum modulo 2^16 into AC and puts the carry out into E. It takes five edges.
- R7: Opcode 3 (0x3aaa) writes AC into memory word aaa and takes four edges.
- R8: The following execute as no operation in four edges, with only PC advancing: opcodes 0, 4, 5 and 6, and opcode 7 with bit 15 set. The word 0x0000 is therefore a no-op.
- R9: Opcode 7 with bit 15 clear is a register operation that takes four edges. Its single-bit codes are: bit 11 clears AC; bit 10 clears E; bit 9 inverts AC; bit 8 inverts E; bit 7 rotates {AC,E} right, so that E enters AC bit 15 and AC bit 0 enters E; bit 6 rotates left, so that E enters AC bit 0 and AC bit 15 enters E; bit 5 increments AC modulo 2^16 and leaves E unchanged.
- R10: Several codes skip the next instruction, which means PC gains one more. Bit 4 skips when AC bit 15 is 0. Bit 3 skips when AC bit 15 is 1. Bit 2 skips when AC is zero. Bit 1 skips when E is 0.
- R11: Code bit 0 halts the core. The timing state freezes, and PC, AC and E hold until reset, with PC pointing past the halt word.
- R12: When several code bits are set in a register operation, only the highest-numbered set bit takes effect.
- R13: PC is 8 bits wide and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Memory load strobe; stalls the core |
| loadAddr | input | 8 | Word address for the load port |
| loadData | input | 16 | Word written through the load port |
| acOut | output | 16 | Accumulator value |
| eOut | output | 1 | Extend flag value |
| pcOut | output | 8 | Program counter value |

## Verification
Counting from the first edge after the load port is released, PC changes at edge 2 of each instruction. A load or add updates AC at edge 5. A store, no-op or register operation finishes at edge 4, and a skip adds its extra PC step at that same edge. The bench samples on falling edges. The directed timing test checks PC after edges 1 and 2 and AC after edges 4 and 5. Each vector program runs well past its halt before AC, E and PC are read, and the halt address proves that the core stopped in the right place. The wrap test checks PC after exactly 1021, 1022 and 1026 edges of back-to-back no-ops.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  localparam int WORD_W   = 16;
  localparam int OPC_LSB  = 12;
  localparam int SEQ_W    = 3;
  localparam int REG_BITS = 12;

  localparam logic [2:0] OPC_ADD = 3'd1;
  localparam logic [2:0] OPC_LDA = 3'd2;
  localparam logic [2:0] OPC_STA = 3'd3;
  localparam logic [2:0] OPC_REG = 3'd7;

  typedef enum logic [2:0] {
    REG_NONE = 3'd0,
    REG_CLA  = 3'd1,
    REG_CLE  = 3'd2,
    REG_CMA  = 3'd3,
    REG_CME  = 3'd4,
    REG_CIR  = 3'd5,
    REG_CIL  = 3'd6,
    REG_INC  = 3'd7
  } regOp_e;

  typedef struct packed {
    logic   arFromPc;
    logic   arFromIr;
    logic   irLoad;
    logic   pcInc;
    logic   drLoad;
    logic   acFromDr;
    logic   acAdd;
    logic   memWrite;
    regOp_e regOp;
  } ctrlStrobe_t;

endpackage

// File: rtl/accCpuAlu.sv
module accCpuAlu
  import accCpuPkg::*;
(
  input  logic [WORD_W-1:0] ac,
  input  logic [WORD_W-1:0] dr,
  input  logic              e,
  input  logic              acAdd,
  input  regOp_e            regOp,
  output logic [WORD_W-1:0] acNext,
  output logic              eNext,
  output logic              acWe,
  output logic              eWe
);

  logic [WORD_W:0] sum;
  assign sum = {1'b0, ac} + {1'b0, dr};

  always_comb begin
    acNext = ac;
    eNext  = e;
    acWe   = 1'b0;
    eWe    = 1'b0;
    if (acAdd) begin
      acNext = sum[WORD_W-1:0];
      eNext  = sum[WORD_W];
      acWe   = 1'b1;
      eWe    = 1'b1;
    end else begin
      case (regOp)
        REG_CLA: begin
          acNext = '0;
          acWe   = 1'b1;
        end
        REG_CLE: begin
          eNext = 1'b0;
          eWe   = 1'b1;
        end
        REG_CMA: begin
          acNext = ~ac;
          acWe   = 1'b1;
        end
        REG_CME: begin
          eNext = ~e;
          eWe   = 1'b1;
        end
        REG_CIR: begin
          acNext = {e, ac[WORD_W-1:1]};
          eNext  = ac[0];
          acWe   = 1'b1;
          eWe    = 1'b1;
        end
        REG_CIL: begin
          acNext = {ac[WORD_W-2:0], e};
          eNext  = ac[WORD_W-1];
          acWe   = 1'b1;
          eWe    = 1'b1;
        end
        REG_INC: begin
          acNext = ac + WORD_W'(1);
          acWe   = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/accCpuCtrl.sv
module accCpuCtrl
  import accCpuPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [WORD_W-1:0] ir,
  input  logic              acZero,
  input  logic              acNeg,
  input  logic              eBit,
  output ctrlStrobe_t       strobe
);

  localparam logic [SEQ_W-1:0] T0 = SEQ_W'(0);
  localparam logic [SEQ_W-1:0] T1 = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] T2 = SEQ_W'(2);
  localparam logic [SEQ_W-1:0] T3 = SEQ_W'(3);

  logic [SEQ_W-1:0]    seqCnt;
  logic                halted;
  logic                haltSet;
  logic                seqDone;
  logic [7:0]          opDec;
  logic                isMemRead;
  logic                isStore;
  logic                isRegRef;
  logic                isOther;
  logic                skipCond;
  logic [REG_BITS-1:0] regSel;
  logic [REG_BITS-1:0] regPick;
  regOp_e              regOpSel;

  // 3-to-8 opcode decoder
  for (genvar k = 0; k < 8; k++) begin : g_opDec
    assign opDec[k] = (ir[OPC_LSB+2:OPC_LSB] == 3'(k));
  end

  assign isMemRead = opDec[OPC_ADD] | opDec[OPC_LDA];
  assign isStore   = opDec[OPC_STA];
  assign isRegRef  = opDec[OPC_REG] & ~ir[WORD_W-1];
  assign isOther   = opDec[0] | opDec[4] | opDec[5] | opDec[6]
                   | (opDec[OPC_REG] & ir[WORD_W-1]);

  // highest-numbered code bit wins
  assign regSel = ir[REG_BITS-1:0];
  always_comb begin
    regPick = '0;
    for (int b = 0; b < REG_BITS; b++) begin
      if (regSel[b]) regPick = REG_BITS'(1) << b;
    end
  end

  always_comb begin
    regOpSel = REG_NONE;
    if (regPick[11])     regOpSel = REG_CLA;
    else if (regPick[10]) regOpSel = REG_CLE;
    else if (regPick[9])  regOpSel = REG_CMA;
    else if (regPick[8])  regOpSel = REG_CME;
    else if (regPick[7])  regOpSel = REG_CIR;
    else if (regPick[6])  regOpSel = REG_CIL;
    else if (regPick[5])  regOpSel = REG_INC;
  end

  assign skipCond = (regPick[4] & ~acNeg) | (regPick[3] & acNeg)
                  | (regPick[2] & acZero) | (regPick[1] & ~eBit);

  always_comb begin
    strobe  = '0;
    haltSet = 1'b0;
    seqDone = 1'b0;
    if (!stall && !halted) begin
      case (seqCnt)
        T0: strobe.arFromPc = 1'b1;
        T1: begin
          strobe.irLoad = 1'b1;
          strobe.pcInc  = 1'b1;
        end
        T2: strobe.arFromIr = 1'b1;
        T3: begin
          strobe.drLoad   = isMemRead;
          strobe.memWrite = isStore;
          seqDone         = isStore | isRegRef | isOther;
          if (isRegRef) begin
            strobe.regOp = regOpSel;
            strobe.pcInc = skipCond;
            haltSet      = regPick[0];
          end
        end
        default: begin
          seqDone         = 1'b1;
          strobe.acAdd    = opDec[OPC_ADD];
          strobe.acFromDr = opDec[OPC_LDA];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqCnt <= T0;
      halted <= 1'b0;
    end else if (!stall && !halted) begin
      seqCnt <= seqDone ? T0 : seqCnt + SEQ_W'(1);
      if (haltSet) halted <= 1'b1;
    end
  end

  // R3: an address-from-PC state is always followed by the instruction fetch
  p_fetch_order_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.arFromPc |=> (stall || strobe.irLoad));

  // R8: a finished instruction returns the sequencer to T0
  p_seq_return_r8: assert property (@(posedge clk) disable iff (rst)
    seqDone |=> (seqCnt == T0));

  // R11: halt is sticky and freezes the timing state
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(seqCnt)));

  // R12: at most one register-group action per instruction
  p_single_action_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.pcInc & (seqCnt == T3), strobe.regOp != REG_NONE, haltSet}));

endmodule

// File: rtl/accCpuDatapath.sv
module accCpuDatapath
  import accCpuPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] irOut,
  output logic              acZero,
  output logic              acNeg,
  output logic [WORD_W-1:0] acOut,
  output logic              eOut,
  output logic [ADDR_W-1:0] pcOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] ar;
  logic [WORD_W-1:0] irReg;
  logic [WORD_W-1:0] dr;
  logic [WORD_W-1:0] ac;
  logic              e;
  logic [WORD_W-1:0] memRd;
  logic [WORD_W-1:0] aluAc;
  logic              aluE;
  logic              aluAcWe;
  logic              aluEWe;

  assign memRd = mem[ar];

  always_ff @(posedge clk) begin
    if (loadEn)               mem[loadAddr] <= loadData;
    else if (strobe.memWrite) mem[ar]       <= ac;
  end

  accCpuAlu u_alu (
    .ac     (ac),
    .dr     (dr),
    .e      (e),
    .acAdd  (strobe.acAdd),
    .regOp  (strobe.regOp),
    .acNext (aluAc),
    .eNext  (aluE),
    .acWe   (aluAcWe),
    .eWe    (aluEWe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ar    <= '0;
      irReg <= '0;
      dr    <= '0;
      ac    <= '0;
      e     <= 1'b0;
    end else begin
      if (strobe.arFromPc)      ar <= pc;
      else if (strobe.arFromIr) ar <= irReg[ADDR_W-1:0];
      if (strobe.irLoad) irReg <= memRd;
      if (strobe.pcInc)  pc    <= pc + ADDR_W'(1);
      if (strobe.drLoad) dr    <= memRd;
      if (strobe.acFromDr) ac <= dr;
      else if (aluAcWe)    ac <= aluAc;
      if (aluEWe) e <= aluE;
    end
  end

  assign irOut  = irReg;
  assign acZero = (ac == '0);
  assign acNeg  = ac[WORD_W-1];
  assign acOut  = ac;
  assign eOut   = e;
  assign pcOut  = pc;

  // R1: loading memory leaves the architectural registers untouched
  p_stall_hold_r1: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> ($stable(ac) && $stable(e) && $stable(pc)));

  // R3: the operand address is the low byte of the instruction
  p_addr_low_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.arFromIr |=> (ar == $past(irReg[ADDR_W-1:0])));

  // R13: each PC step is exactly one, modulo the address space
  p_pc_step_r13: assert property (@(posedge clk) disable iff (rst)
    strobe.pcInc |=> (pc == $past(pc) + ADDR_W'(1)));

  // R6: carry of the addition lands in E
  p_add_carry_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.acAdd |=> ({e, ac} == $past({1'b0, ac}) + $past({1'b0, dr})));

endmodule

// File: rtl/accCpuCore.sv
module accCpuCore
  import accCpuPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  output logic [WORD_W-1:0] acOut,
  output logic              eOut,
  output logic [ADDR_W-1:0] pcOut
);

  ctrlStrobe_t       strobe;
  logic [WORD_W-1:0] irBus;
  logic              acZero;
  logic              acNeg;

  accCpuCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stall  (loadEn),
    .ir     (irBus),
    .acZero (acZero),
    .acNeg  (acNeg),
    .eBit   (eOut),
    .strobe (strobe)
  );

  accCpuDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .strobe   (strobe),
    .irOut    (irBus),
    .acZero   (acZero),
    .acNeg    (acNeg),
    .acOut    (acOut),
    .eOut     (eOut),
    .pcOut    (pcOut)
  );

endmodule

// File: tb/accCpuCore_tb.sv
`timescale 1ns/1ps
module accCpuCore_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [15:0] acOut;
  logic        eOut;
  logic [7:0]  pcOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  accCpuCore u_dut (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .acOut    (acOut),
    .eOut     (eOut),
    .pcOut    (pcOut)
  );

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] acInit;
    logic        eInit;
    logic [15:0] operand;
    logic [15:0] expAc;
    logic        expE;
    logic [7:0]  expPc;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 28;
  localparam vec_t VECS [NVEC] = '{
    '{16'h2011, 16'h1234, 1'b0, 16'h0F0F, 16'h0F0F, 1'b0, 8'd5, 4'd5 },  // R5 load
    '{16'h2F11, 16'h1234, 1'b1, 16'h0F0F, 16'h0F0F, 1'b1, 8'd5, 4'd3 },  // R3 high address bits ignored
    '{16'hA011, 16'h1234, 1'b0, 16'h0F0F, 16'h0F0F, 1'b0, 8'd5, 4'd4 },  // R4 bit 15 ignored
    '{16'h1011, 16'h0F0F, 1'b0, 16'hF102, 16'h0011, 1'b1, 8'd5, 4'd6 },  // R6 carry out
    '{16'h1011, 16'h0001, 1'b1, 16'h0002, 16'h0003, 1'b0, 8'd5, 4'd6 },  // R6 carry clears E
    '{16'h1011, 16'hFFFF, 1'b0, 16'h0001, 16'h0000, 1'b1, 8'd5, 4'd6 },  // R6 wrap to zero
    '{16'h0000, 16'h5A5A, 1'b1, 16'h0000, 16'h5A5A, 1'b1, 8'd5, 4'd8 },  // R8 zero word
    '{16'h4011, 16'h5A5A, 1'b0, 16'h0000, 16'h5A5A, 1'b0, 8'd5, 4'd8 },  // R8 opcode 4
    '{16'hF800, 16'h5A5A, 1'b1, 16'h0000, 16'h5A5A, 1'b1, 8'd5, 4'd8 },  // R8 opcode 7 with bit 15
    '{16'h7800, 16'h5A5A, 1'b1, 16'h0000, 16'h0000, 1'b1, 8'd5, 4'd9 },  // R9 clear AC
    '{16'h7400, 16'h5A5A, 1'b1, 16'h0000, 16'h5A5A, 1'b0, 8'd5, 4'd9 },  // R9 clear E
    '{16'h7200, 16'h5A5A, 1'b0, 16'h0000, 16'hA5A5, 1'b0, 8'd5, 4'd9 },  // R9 invert AC
    '{16'h7100, 16'h5A5A, 1'b0, 16'h0000, 16'h5A5A, 1'b1, 8'd5, 4'd9 },  // R9 invert E
    '{16'h7080, 16'h0003, 1'b1, 16'h0000, 16'h8001, 1'b1, 8'd5, 4'd9 },  // R9 rotate right
    '{16'h7080, 16'h8000, 1'b0, 16'h0000, 16'h4000, 1'b0, 8'd5, 4'd9 },  // R9 rotate right
    '{16'h7040, 16'h8001, 1'b0, 16'h0000, 16'h0002, 1'b1, 8'd5, 4'd9 },  // R9 rotate left
    '{16'h7020, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'd5, 4'd9 },  // R9 increment wraps, E kept
    '{16'h7010, 16'h0001, 1'b0, 16'h0000, 16'h0001, 1'b0, 8'd6, 4'd10},  // R10 positive skips
    '{16'h7010, 16'h8000, 1'b0, 16'h0000, 16'h8000, 1'b0, 8'd5, 4'd10},  // R10 positive no skip
    '{16'h7008, 16'h8000, 1'b1, 16'h0000, 16'h8000, 1'b1, 8'd6, 4'd10},  // R10 negative skips
    '{16'h7004, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'd6, 4'd10},  // R10 zero skips
    '{16'h7004, 16'h0001, 1'b0, 16'h0000, 16'h0001, 1'b0, 8'd5, 4'd10},  // R10 zero no skip
    '{16'h7002, 16'h1111, 1'b0, 16'h0000, 16'h1111, 1'b0, 8'd6, 4'd10},  // R10 E clear skips
    '{16'h7002, 16'h1111, 1'b1, 16'h0000, 16'h1111, 1'b1, 8'd5, 4'd10},  // R10 E set no skip
    '{16'h7820, 16'h5A5A, 1'b0, 16'h0000, 16'h0000, 1'b0, 8'd5, 4'd12},  // R12 clear beats increment
    '{16'h7021, 16'h0007, 1'b0, 16'h0000, 16'h0008, 1'b0, 8'd5, 4'd12},  // R12 increment beats halt
    '{16'h7006, 16'h0001, 1'b0, 16'h0000, 16'h0001, 1'b0, 8'd5, 4'd12},  // R12 zero test beats E test
    '{16'h7001, 16'h2222, 1'b1, 16'h0000, 16'h2222, 1'b1, 8'd4, 4'd11}   // R11 halt in place
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadWord(input logic [7:0] a, input logic [15:0] d);
    loadEn   = 1'b1;
    loadAddr = a;
    loadData = d;
    @(negedge clk);
  endtask

  task automatic release_core();
    rst    = 1'b0;
    loadEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  pcHold;
    logic [15:0] acHold;
    string tag;

    // R2: reset state
    rst = 1'b1;
    step(2);
    check("R2", "pc after reset", pcOut, 8'h00);
    check("R2", "ac after reset", acOut, 16'h0000);
    check("R2", "e after reset", eOut, 1'b0);

    // Vector table: LDA, E setup, instruction under test, halts, data
    for (int i = 0; i < NVEC; i++) begin
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      rst = 1'b1;
      loadWord(8'h00, 16'h2010);
      loadWord(8'h01, 16'h7400);
      loadWord(8'h02, VECS[i].eInit ? 16'h7100 : 16'h0000);
      loadWord(8'h03, VECS[i].instr);
      loadWord(8'h04, 16'h7001);
      loadWord(8'h05, 16'h7001);
      loadWord(8'h10, VECS[i].acInit);
      loadWord(8'h11, VECS[i].operand);
      release_core();
      step(40);
      check(tag, "ac", acOut, VECS[i].expAc);
      check(tag, "e", eOut, VECS[i].expE);
      check(tag, "pc", pcOut, VECS[i].expPc);
    end

    // R2: reset clears a loaded, halted state
    rst = 1'b1;
    step(1);
    check("R2", "pc after mid reset", pcOut, 8'h00);
    check("R2", "ac after mid reset", acOut, 16'h0000);
    check("R2", "e after mid reset", eOut, 1'b0);

    // R3 / R5: exact cycle timing of fetch and load
    loadWord(8'h00, 16'h2010);
    loadWord(8'h01, 16'h7001);
    loadWord(8'h10, 16'h0BAD);
    release_core();
    step(1);
    check("R3", "pc after edge 1", pcOut, 8'h00);
    step(1);
    check("R3", "pc after edge 2", pcOut, 8'h01);
    step(2);
    check("R5", "ac after edge 4", acOut, 16'h0000);
    step(1);
    check("R5", "ac after edge 5", acOut, 16'h0BAD);

    // R7 store with an R1 stall in the middle of the run
    rst = 1'b1;
    loadWord(8'h00, 16'h2010);
    loadWord(8'h01, 16'h3013);
    loadWord(8'h02, 16'h2014);
    loadWord(8'h03, 16'h2013);
    loadWord(8'h04, 16'h7001);
    loadWord(8'h10, 16'hBEEF);
    loadWord(8'h13, 16'h0000);
    loadWord(8'h14, 16'h1111);
    release_core();
    step(7);
    pcHold = pcOut;
    acHold = acOut;
    check("R1", "pc before stall", pcHold, 8'h02);
    loadEn   = 1'b1;
    loadAddr = 8'h40;
    loadData = 16'hFFFF;
    step(10);
    check("R1", "pc held in stall", pcOut, pcHold);
    check("R1", "ac held in stall", acOut, acHold);
    loadEn = 1'b0;
    step(40);
    check("R7", "ac after store and reload", acOut, 16'hBEEF);
    check("R7", "pc at halt", pcOut, 8'h05);

    // R13: PC wraps across 256 no-ops
    rst = 1'b1;
    for (int a = 0; a < 256; a++) loadWord(8'(a), 16'h0000);
    release_core();
    step(1021);
    check("R13", "pc before wrap", pcOut, 8'hFF);
    step(1);
    check("R13", "pc after wrap", pcOut, 8'h00);
    step(4);
    check("R13", "pc after next no-op", pcOut, 8'h01);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule